// File: doc/BRIEF.md
# Hardware Stack Pointer with Context Save

This block keeps the call and interrupt stack of an 8-bit processor core in a small on-chip byte RAM. It holds a 16-bit stack pointer. The upper bits of the pointer are tied by parameter, so every access falls inside a fixed 64-byte window, from 00C0h to 00FFh in the default build. The pointer always addresses the next free byte. It moves down on a store and up on a restore. When it runs past either end of the window it wraps to the other end without any flag.

The core issues one command per cycle on a 3-bit code and supplies the register values the command needs. The command set covers:
- single-byte push and pop;
- a two-byte return-address save for a call, and its matching return;
- a five-byte context save for interrupt entry, and its matching return from interrupt;
- a pointer reset.

The low byte of the pointer can be read at any time and loaded directly. A small sequencer moves one byte per clock through the RAM port. It holds `busy` while it works and pulses `done` when the values are stored or restored.

Top module: `hw_stack`

## Requirements
- R1: After reset, and one clock after an accepted reset command (code 7), `sp` is 00FFh. `busy` and `done` are low after reset. The reset command pulses `done` on the edge that accepts it.
- R2: `sp[15:6]` always reads 0000_0000_11b. A direct load changes only `sp[5:0]`, so loading 7Fh yields 00FFh.
- R3: A push (code 1) writes `push_data` at the byte `sp` addresses and then decrements `sp`. A pop (code 2) first increments `sp`, then returns the addressed byte on `pop_data`.
- R4: A store at 00C0h leaves `sp` at 00FFh, and a restore from 00FFh reads address 00C0h. No flag is raised, and the old contents are overwritten.
- R5: A call save (code 3) stores the PC low byte at `sp` and the PC high byte one below it, leaving `sp` two lower. A return (code 4) restores the high byte first, then the low byte, onto `pc_out`, leaving `sp` two higher.
- R6: An interrupt save (code 5) stores, from `sp` downward, PC low, PC high, X, A, CC, and leaves `sp` five lower. A return from interrupt (code 6) restores CC, A, X, PC high and PC low in that order onto the outputs, and leaves `sp` five higher.
- R7: One byte moves per clock. For a command that stores n bytes, `done` pulses on the nth edge after the accepting edge. For a command that restores n bytes, it pulses on edge n+1. `busy` is high from the accepting edge until `done` rises.
- R8: Asserting `sp_wr` while idle loads `sp_wdata[5:0]` into `sp[5:0]` on that edge.
- R9: If `sp_wr` and a command arrive in the same idle cycle, the load takes effect and the command is dropped. The RAM is not written and `done` does not pulse.
- R10: Commands and `sp_wr` that arrive while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Command code: 0 none, 1 push, 2 pop, 3 call save, 4 return, 5 interrupt save, 6 interrupt return, 7 pointer reset |
| push_data | input | 8 | Byte stored by a push |
| pc_in | input | 16 | Program counter stored by call and interrupt saves |
| x_in | input | 8 | X register for the interrupt save |
| a_in | input | 8 | Accumulator for the interrupt save |
| cc_in | input | 8 | Condition codes for the interrupt save |
| sp_wr | input | 1 | Direct load strobe for the pointer low byte |
| sp_wdata | input | 8 | Value for the direct load |
| sp | output | 16 | Current stack pointer |
| busy | output | 1 | Sequencer is working on a command |
| done | output | 1 | One-cycle pulse when a command completes |
| pop_data | output | 8 | Byte returned by the last pop |
| pc_out | output | 16 | Program counter restored by a return |
| x_out | output | 8 | X restored by the interrupt return |
| a_out | output | 8 | Accumulator restored by the interrupt return |
| cc_out | output | 8 | Condition codes restored by the interrupt return |

## Verification
The bench builds the block with its default parameters: a 16-bit pointer, a 6-bit window offset and a top of 00FFh. With these values, a single direct load of 00h places the pointer on the bottom edge, so both wrap directions can be reached in one push and one pop. The five-byte frame fits many times in the window, so the byte order of a frame can be read back one pop at a time. The bench then compares each popped byte against the order given in R5 and R6.

// File: rtl/stk_pkg.sv
`timescale 1ns/1ps
package stk_pkg;
  localparam int BYTE_W    = 8;
  localparam int FRAME_MAX = 5;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_PUSH = 3'd1,
    OP_POP  = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4,
    OP_INT  = 3'd5,
    OP_IRET = 3'd6,
    OP_RSP  = 3'd7
  } stk_op_e;

  typedef logic [FRAME_MAX-1:0][BYTE_W-1:0] frame_t;
endpackage

// File: rtl/stk_ram.sv
`timescale 1ns/1ps
module stk_ram #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  // Simple dual-port, registered read: maps onto a block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/stk_ptr.sv
`timescale 1ns/1ps
module stk_ptr #(
  parameter int              PW  = 16,
  parameter int              DB  = 6,
  parameter logic [PW-1:0]   TOP = 16'h00FF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rsp,
  input  logic          load,
  input  logic [DB-1:0] load_val,
  input  logic          dec,
  input  logic          inc,
  output logic [PW-1:0] sp,
  output logic [DB-1:0] next_up
);
  localparam logic [PW-DB-1:0] HI = TOP[PW-1:DB];

  logic [DB-1:0] off;

  // Offset arithmetic is modulo the window size, which gives the silent wrap.
  always_ff @(posedge clk) begin
    if (rst || rsp)  off <= '1;
    else if (load)   off <= load_val;
    else if (dec)    off <= off - 1'b1;
    else if (inc)    off <= off + 1'b1;
  end

  assign sp      = {HI, off};
  assign next_up = off + 1'b1;
endmodule

// File: rtl/stk_seq.sv
`timescale 1ns/1ps
module stk_seq
  import stk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  stk_op_e           cmd,
  input  logic [BYTE_W-1:0] push_data,
  input  logic [15:0]       pc_in,
  input  logic [BYTE_W-1:0] x_in,
  input  logic [BYTE_W-1:0] a_in,
  input  logic [BYTE_W-1:0] cc_in,
  input  logic              sp_wr,
  input  logic [BYTE_W-1:0] ram_rdata,
  output logic              ram_we,
  output logic [BYTE_W-1:0] ram_wdata,
  output logic              ptr_rsp,
  output logic              ptr_load,
  output logic              ptr_dec,
  output logic              ptr_inc,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] pop_data,
  output logic [15:0]       pc_out,
  output logic [BYTE_W-1:0] x_out,
  output logic [BYTE_W-1:0] a_out,
  output logic [BYTE_W-1:0] cc_out
);
  typedef enum logic [1:0] {S_IDLE, S_STORE, S_FETCH} state_e;

  state_e           state;
  stk_op_e          op_q;
  frame_t           bytes_q, frame;
  logic [CNT_W-1:0] cnt, len, flen, cap_idx;
  logic             cap_vld, idle, accept, is_store;

  assign idle   = (state == S_IDLE) && !cap_vld;
  assign busy   = !idle;
  assign accept = idle && (cmd != OP_NONE) && !sp_wr;

  assign ptr_load  = idle && sp_wr;
  assign ptr_rsp   = accept && (cmd == OP_RSP);
  assign ptr_dec   = (state == S_STORE);
  assign ptr_inc   = (state == S_FETCH);
  assign ram_we    = (state == S_STORE);
  assign ram_wdata = bytes_q[cnt];

  // Frame layout in store order; restores only use the length.
  always_comb begin
    frame    = '0;
    flen     = CNT_W'(1);
    is_store = 1'b0;
    unique case (cmd)
      OP_PUSH: begin frame[0] = push_data; is_store = 1'b1; end
      OP_CALL: begin
        frame[0] = pc_in[7:0]; frame[1] = pc_in[15:8];
        flen = CNT_W'(2); is_store = 1'b1;
      end
      OP_INT: begin
        frame[0] = pc_in[7:0]; frame[1] = pc_in[15:8];
        frame[2] = x_in; frame[3] = a_in; frame[4] = cc_in;
        flen = CNT_W'(FRAME_MAX); is_store = 1'b1;
      end
      OP_RET:  flen = CNT_W'(2);
      OP_IRET: flen = CNT_W'(FRAME_MAX);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      op_q     <= OP_NONE;
      bytes_q  <= '0;
      cnt      <= '0;
      len      <= '0;
      cap_vld  <= 1'b0;
      cap_idx  <= '0;
      done     <= 1'b0;
      pop_data <= '0;
      pc_out   <= '0;
      x_out    <= '0;
      a_out    <= '0;
      cc_out   <= '0;
    end else begin
      done    <= 1'b0;
      cap_vld <= 1'b0;
      unique case (state)
        S_IDLE: if (accept) begin
          op_q    <= cmd;
          bytes_q <= frame;
          len     <= flen;
          cnt     <= '0;
          if (cmd == OP_RSP) done  <= 1'b1;
          else if (is_store) state <= S_STORE;
          else               state <= S_FETCH;
        end
        S_STORE: begin
          cnt <= cnt + 1'b1;
          if (cnt == len - 1'b1) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end
        S_FETCH: begin
          cap_vld <= 1'b1;
          cap_idx <= cnt;
          cnt     <= cnt + 1'b1;
          if (cnt == len - 1'b1) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
      // Read data arrives one edge after the address was issued.
      if (cap_vld) begin
        if (cap_idx == len - 1'b1) done <= 1'b1;
        if (op_q == OP_POP) pop_data <= ram_rdata;
        else if (op_q == OP_RET) begin
          if (cap_idx == 0) pc_out[15:8] <= ram_rdata;
          else              pc_out[7:0]  <= ram_rdata;
        end else begin
          unique case (cap_idx)
            CNT_W'(0): cc_out       <= ram_rdata;
            CNT_W'(1): a_out        <= ram_rdata;
            CNT_W'(2): x_out        <= ram_rdata;
            CNT_W'(3): pc_out[15:8] <= ram_rdata;
            default:   pc_out[7:0]  <= ram_rdata;
          endcase
        end
      end
    end
  end

  // R7: a completion pulse always leaves the sequencer free for a new command.
  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: rtl/hw_stack.sv
`timescale 1ns/1ps
module hw_stack
  import stk_pkg::*;
#(
  parameter int            PTR_W      = 16,
  parameter int            DEPTH_BITS = 6,
  parameter logic [PTR_W-1:0] STACK_TOP = 16'h00FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cmd,
  input  logic [BYTE_W-1:0] push_data,
  input  logic [15:0]       pc_in,
  input  logic [BYTE_W-1:0] x_in,
  input  logic [BYTE_W-1:0] a_in,
  input  logic [BYTE_W-1:0] cc_in,
  input  logic              sp_wr,
  input  logic [BYTE_W-1:0] sp_wdata,
  output logic [PTR_W-1:0]  sp,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] pop_data,
  output logic [15:0]       pc_out,
  output logic [BYTE_W-1:0] x_out,
  output logic [BYTE_W-1:0] a_out,
  output logic [BYTE_W-1:0] cc_out
);
  logic                  ram_we, ptr_rsp, ptr_load, ptr_dec, ptr_inc;
  logic [BYTE_W-1:0]     ram_wdata, ram_rdata;
  logic [DEPTH_BITS-1:0] next_up;

  stk_seq u_seq (
    .clk(clk), .rst(rst), .cmd(stk_op_e'(cmd)), .push_data(push_data),
    .pc_in(pc_in), .x_in(x_in), .a_in(a_in), .cc_in(cc_in), .sp_wr(sp_wr),
    .ram_rdata(ram_rdata), .ram_we(ram_we), .ram_wdata(ram_wdata),
    .ptr_rsp(ptr_rsp), .ptr_load(ptr_load), .ptr_dec(ptr_dec),
    .ptr_inc(ptr_inc), .busy(busy), .done(done), .pop_data(pop_data),
    .pc_out(pc_out), .x_out(x_out), .a_out(a_out), .cc_out(cc_out)
  );

  stk_ptr #(.PW(PTR_W), .DB(DEPTH_BITS), .TOP(STACK_TOP)) u_ptr (
    .clk(clk), .rst(rst), .rsp(ptr_rsp), .load(ptr_load),
    .load_val(sp_wdata[DEPTH_BITS-1:0]), .dec(ptr_dec), .inc(ptr_inc),
    .sp(sp), .next_up(next_up)
  );

  stk_ram #(.DW(BYTE_W), .AW(DEPTH_BITS)) u_ram (
    .clk(clk), .we(ram_we), .waddr(sp[DEPTH_BITS-1:0]), .wdata(ram_wdata),
    .raddr(next_up), .rdata(ram_rdata)
  );

  // Checker-side history of the pointer offset.
  logic [DEPTH_BITS-1:0] prev_off, sp_delta;
  always_ff @(posedge clk) prev_off <= sp[DEPTH_BITS-1:0];
  assign sp_delta = sp[DEPTH_BITS-1:0] - prev_off;

  // R1: the reset command puts the pointer back at the top of the window.
  p_rsp_top_r1: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'd7 && !busy && !sp_wr) |=> sp == STACK_TOP);

  // R8: an idle direct load sets the window offset from the written byte.
  p_load_r8: assert property (@(posedge clk) disable iff (rst)
    (sp_wr && !busy) |=> sp[DEPTH_BITS-1:0] == $past(sp_wdata[DEPTH_BITS-1:0]));

  // R7 and R10: while busy the pointer moves at most one byte per clock.
  p_step_r7: assert property (@(posedge clk) disable iff (rst)
    busy |=> (sp_delta == '0 || sp_delta == DEPTH_BITS'(1) || sp_delta == '1));

  // R3: the RAM is never written and read-advanced in the same cycle.
  p_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(ram_we && ptr_inc));
endmodule

// File: tb/hw_stack_tb.sv
`timescale 1ns/1ps
module hw_stack_tb;
  localparam logic [2:0] C_NONE = 3'd0, C_PUSH = 3'd1, C_POP = 3'd2,
                         C_CALL = 3'd3, C_RET = 3'd4, C_INT = 3'd5,
                         C_IRET = 3'd6, C_RSP = 3'd7;

  logic        clk = 1'b0, rst = 1'b1, sp_wr = 1'b0;
  logic [2:0]  cmd = C_NONE;
  logic [7:0]  push_data = '0, x_in = '0, a_in = '0, cc_in = '0, sp_wdata = '0;
  logic [15:0] pc_in = '0;
  logic [15:0] sp, pc_out;
  logic        busy, done;
  logic [7:0]  pop_data, x_out, a_out, cc_out;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  hw_stack u_dut (
    .clk(clk), .rst(rst), .cmd(cmd), .push_data(push_data), .pc_in(pc_in),
    .x_in(x_in), .a_in(a_in), .cc_in(cc_in), .sp_wr(sp_wr),
    .sp_wdata(sp_wdata), .sp(sp), .busy(busy), .done(done),
    .pop_data(pop_data), .pc_out(pc_out), .x_out(x_out), .a_out(a_out),
    .cc_out(cc_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive one command; lat = edges after the accepting edge until done.
  task automatic issue(input logic [2:0] op, output int lat);
    @(negedge clk);
    cmd = op;
    @(negedge clk);
    cmd = C_NONE;
    lat = 0;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic load(input logic [7:0] v);
    @(negedge clk);
    sp_wr = 1'b1; sp_wdata = v;
    @(negedge clk);
    sp_wr = 1'b0;
  endtask

  task automatic do_push(input logic [7:0] d, output int lat);
    push_data = d;
    issue(C_PUSH, lat);
  endtask

  task automatic t_reset;
    chk(sp == 16'h00FF, "R1 reset sp", sp, 16'h00FF);
    chk(!busy && !done, "R1 reset idle", {busy, done}, 0);
  endtask

  task automatic t_push_pop;
    int lat;
    do_push(8'hA5, lat);
    chk(lat == 1, "R7 push latency", lat, 1);
    chk(sp == 16'h00FE, "R3 push dec", sp, 16'h00FE);
    do_push(8'h3C, lat);
    issue(C_POP, lat);
    chk(lat == 2, "R7 pop latency", lat, 2);
    chk(pop_data == 8'h3C, "R3 pop data", pop_data, 8'h3C);
    chk(sp == 16'h00FE, "R3 pop inc", sp, 16'h00FE);
    issue(C_POP, lat);
    chk(pop_data == 8'hA5, "R3 pop lifo", pop_data, 8'hA5);
    chk(sp == 16'h00FF, "R3 pop back to top", sp, 16'h00FF);
  endtask

  task automatic t_load;
    load(8'hC7);
    chk(sp == 16'h00C7, "R8 load low byte", sp, 16'h00C7);
    load(8'h7F);
    chk(sp == 16'h00FF, "R2 high bits fixed", sp, 16'h00FF);
  endtask

  task automatic t_wrap;
    int lat;
    load(8'h00);
    chk(sp == 16'h00C0, "R2 bottom", sp, 16'h00C0);
    do_push(8'h5A, lat);
    chk(sp == 16'h00FF, "R4 wrap down", sp, 16'h00FF);
    issue(C_POP, lat);
    chk(sp == 16'h00C0, "R4 wrap up", sp, 16'h00C0);
    chk(pop_data == 8'h5A, "R4 wrap data", pop_data, 8'h5A);
  endtask

  task automatic t_call;
    int lat;
    issue(C_RSP, lat);
    chk(lat == 0 && sp == 16'h00FF, "R1 reset command", {lat[15:0], sp}, 16'h00FF);
    pc_in = 16'h1234;
    issue(C_CALL, lat);
    chk(lat == 2, "R5 call latency", lat, 2);
    chk(sp == 16'h00FD, "R5 call depth", sp, 16'h00FD);
    issue(C_POP, lat);
    chk(pop_data == 8'h12, "R5 PCH below PCL", pop_data, 8'h12);
    issue(C_POP, lat);
    chk(pop_data == 8'h34, "R5 PCL at sp", pop_data, 8'h34);
    pc_in = 16'hA1B2;
    issue(C_CALL, lat);
    issue(C_RET, lat);
    chk(lat == 3, "R7 return latency", lat, 3);
    chk(pc_out == 16'hA1B2, "R5 return pc", pc_out, 16'hA1B2);
    chk(sp == 16'h00FF, "R5 return depth", sp, 16'h00FF);
  endtask

  task automatic t_int;
    int lat;
    pc_in = 16'hBEEF; x_in = 8'h11; a_in = 8'h22; cc_in = 8'h33;
    issue(C_INT, lat);
    chk(lat == 5, "R7 interrupt latency", lat, 5);
    chk(sp == 16'h00FA, "R6 interrupt depth", sp, 16'h00FA);
    issue(C_POP, lat); chk(pop_data == 8'h33, "R6 CC slot", pop_data, 8'h33);
    issue(C_POP, lat); chk(pop_data == 8'h22, "R6 A slot", pop_data, 8'h22);
    issue(C_POP, lat); chk(pop_data == 8'h11, "R6 X slot", pop_data, 8'h11);
    issue(C_POP, lat); chk(pop_data == 8'hBE, "R6 PCH slot", pop_data, 8'hBE);
    issue(C_POP, lat); chk(pop_data == 8'hEF, "R6 PCL slot", pop_data, 8'hEF);
    pc_in = 16'hCAFE; x_in = 8'h44; a_in = 8'h55; cc_in = 8'h66;
    issue(C_INT, lat);
    issue(C_IRET, lat);
    chk(lat == 6, "R7 iret latency", lat, 6);
    chk(pc_out == 16'hCAFE, "R6 iret pc", pc_out, 16'hCAFE);
    chk({x_out, a_out, cc_out} == 24'h445566, "R6 iret regs",
        {x_out, a_out, cc_out}, 24'h445566);
    chk(sp == 16'h00FF, "R6 iret depth", sp, 16'h00FF);
  endtask

  task automatic t_collide;
    int lat;
    bit seen = 0;
    @(negedge clk);
    cmd = C_PUSH; push_data = 8'h77; sp_wr = 1'b1; sp_wdata = 8'h10;
    @(negedge clk);
    cmd = C_NONE; sp_wr = 1'b0;
    for (int i = 0; i < 3; i++) begin
      if (done || busy) seen = 1;
      @(negedge clk);
    end
    chk(sp == 16'h00D0, "R9 load wins", sp, 16'h00D0);
    chk(!seen, "R9 command dropped", seen, 0);
    load(8'hFE);
    issue(C_POP, lat);
    chk(pop_data == 8'hFE, "R9 no ram write", pop_data, 8'hFE);
  endtask

  task automatic t_busy;
    int lat;
    issue(C_RSP, lat);
    pc_in = 16'h0102; x_in = 8'h03; a_in = 8'h04; cc_in = 8'h05;
    @(negedge clk);
    cmd = C_INT;
    @(negedge clk);
    cmd = C_PUSH; push_data = 8'h99; sp_wr = 1'b1; sp_wdata = 8'h20;
    @(negedge clk);
    @(negedge clk);
    cmd = C_NONE; sp_wr = 1'b0;
    lat = 0;
    while (!done && lat < 20) begin @(negedge clk); lat++; end
    chk(sp == 16'h00FA, "R10 busy ignores", sp, 16'h00FA);
    issue(C_IRET, lat);
    chk(pc_out == 16'h0102 && cc_out == 8'h05, "R10 frame intact",
        {pc_out, cc_out}, 24'h010205);
    chk(sp == 16'h00FF, "R10 depth", sp, 16'h00FF);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_push_pop();
    t_load();
    t_wrap();
    t_call();
    t_int();
    t_collide();
    t_busy();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule